// File: doc/BRIEF.md
# Program Trace Fetch Show Controller

This block sits between an instruction-fetch unit and the external bus interface. For every accepted fetch it decides whether the fetch is exposed on the external bus so that an outside trace tool can rebuild the program flow. It outputs a trace-attribute bit and the kind of external cycle to run: none, address-only, or a full cycle with address and data phases.

Fetches caused by an indirect change of program flow are marked for trace. A debug-port-driven synchronisation level, here called `vsync_lvl`, forces all marked fetches to be shown while it is high. Each of its edges, rising or falling, also arms a resync, which marks and shows the next accepted fetch. A 2-bit show mode can force showing independently of that level.

Fetches arrive on a valid/ready stream. The result leaves on a registered valid/ready stream, one cycle after acceptance. While the result is stalled (`out_valid` high, `bus_ready` low) the result is held and `fetch_ready` is low. A new fetch can be taken in the same cycle the held result is consumed.

Top module: `trace_show_ctrl`

## Requirements
- R1: A fetch with `fetch_indirect`=1 that is shown reports `out_attr`=1.
- R2: A sequential fetch (`fetch_indirect`=0) with no pending resync reports `out_attr`=0 in every mode.
- R3: While `vsync_lvl`=1, every marked fetch is shown with `out_attr`=1, even when `fetch_int_hit`=1.
- R4: A rise or fall of `vsync_lvl` arms a resync. The next accepted fetch reports `out_resync`=1 and `out_attr`=1 and is shown. The following fetch has `out_resync`=0.
- R5: If a `vsync_lvl` edge is seen in the same cycle a fetch is accepted, that fetch does not carry the resync. The next fetch does.
- R6: `out_kind` uses the encoding 00=none, 01=address-only, 10=full; 11 never appears. A shown fetch reports 01 on an internal hit and 10 otherwise. A fetch that is not shown reports 00 on an internal hit, and 10 with `out_attr`=0 otherwise.
- R7: `show_mode`=00 shows every fetch.
- R8: `show_mode`=01 shows every marked fetch whatever the `vsync_lvl` level. Unmarked internal-hit fetches report none.
- R9: `show_mode`=11 shows only what `vsync_lvl` or a resync forces. `show_mode`=10 behaves exactly as 11.
- R10: An accepted fetch appears on `out_*` with `out_valid`=1 at the next clock edge. While `bus_ready`=0, the output is held unchanged and `fetch_ready`=0.
- R11: Synchronous reset clears `out_valid`, `out_attr`, `out_kind`, the pending resync and the edge-detect copy of `vsync_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Fetch accepted when high with valid |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_indirect | input | 1 | Fetch caused by indirect flow change |
| fetch_int_hit | input | 1 | Instruction served from internal memory |
| vsync_lvl | input | 1 | Trace synchronisation level from debug port |
| show_mode | input | 2 | 00 all, 01 marked, 10/11 forced only |
| out_valid | output | 1 | Result valid |
| bus_ready | input | 1 | Bus interface takes the result |
| out_addr | output | ADDR_W | Address of the reported fetch |
| out_attr | output | 1 | Program-trace attribute |
| out_kind | output | 2 | External cycle kind |
| out_resync | output | 1 | Fetch is the resynchronisation fetch |

## Verification
The assertions check on every cycle that:
- an edge of `vsync_lvl` arms the resync flag;
- acceptance without an edge clears the flag;
- the 11 kind never appears;
- a resync result is always shown with its attribute set;
- a stalled result stays stable.

Only the bench scenarios can show the show/hide decision of each mode against `vsync_lvl`, and the coincidence of an edge with acceptance. They also show the exact address-only versus full choice for given hit flags.

// File: rtl/trace_show_pkg.sv
package trace_show_pkg;
  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_ADDR = 2'b01,
    KIND_FULL = 2'b10
  } bus_kind_e;

  localparam logic [1:0] MODE_ALL    = 2'b00;
  localparam logic [1:0] MODE_MARKED = 2'b01;
endpackage

// File: rtl/tsc_resync_track.sv
module tsc_resync_track (
  input  logic clk,
  input  logic rst,
  input  logic vsync_lvl,
  input  logic accept,
  output logic pend_o,
  output logic edge_o
);
  logic vs_q;
  logic pend_q;

  assign edge_o = vsync_lvl ^ vs_q;
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      vs_q <= vsync_lvl;
      if (edge_o)      pend_q <= 1'b1;
      else if (accept) pend_q <= 1'b0;
    end
  end

  // R4: any edge arms the resync
  a_r4_edge_arms: assert property (@(posedge clk) disable iff (rst)
    (vsync_lvl != vs_q) |=> pend_q);
  // R5: edge with acceptance keeps flag for following fetch
  a_r5_edge_accept_keeps: assert property (@(posedge clk) disable iff (rst)
    (accept && (vsync_lvl != vs_q)) |=> pend_q);
  // R4: acceptance without edge consumes flag
  a_r4_accept_clears: assert property (@(posedge clk) disable iff (rst)
    (accept && (vsync_lvl == vs_q)) |=> !pend_q);
endmodule

// File: rtl/tsc_classify.sv
module tsc_classify
  import trace_show_pkg::*;
(
  input  logic       indirect,
  input  logic       int_hit,
  input  logic       resync,
  input  logic       vsync_lvl,
  input  logic [1:0] show_mode,
  output logic       attr,
  output bus_kind_e  kind
);
  logic marked;
  logic shown;

  always_comb begin
    marked = indirect | resync;
    shown  = resync
           | (show_mode == MODE_ALL)
           | (marked & ((show_mode == MODE_MARKED) | vsync_lvl));
    attr   = marked & shown;
    if (!int_hit)   kind = KIND_FULL;
    else if (shown) kind = KIND_ADDR;
    else            kind = KIND_NONE;
  end
endmodule

// File: rtl/tsc_out_slice.sv
module tsc_out_slice
  import trace_show_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              take,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              attr_i,
  input  bus_kind_e         kind_i,
  input  logic              resync_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              attr_o,
  output bus_kind_e         kind_o,
  output logic              resync_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      addr_o   <= '0;
      attr_o   <= 1'b0;
      kind_o   <= KIND_NONE;
      resync_o <= 1'b0;
    end else if (load) begin
      valid_o  <= 1'b1;
      addr_o   <= addr_i;
      attr_o   <= attr_i;
      kind_o   <= kind_i;
      resync_o <= resync_i;
    end else if (take) begin
      valid_o  <= 1'b0;
      attr_o   <= 1'b0;
      kind_o   <= KIND_NONE;
      resync_o <= 1'b0;
    end
  end

  // R10: stalled result is held
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !take) |=> (valid_o && $stable(addr_o) && $stable(kind_o)
                            && $stable(attr_o) && $stable(resync_o)));
endmodule

// File: rtl/trace_show_ctrl.sv
module trace_show_ctrl
  import trace_show_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_indirect,
  input  logic              fetch_int_hit,
  input  logic              vsync_lvl,
  input  logic [1:0]        show_mode,
  output logic              out_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_attr,
  output logic [1:0]        out_kind,
  output logic              out_resync
);
  logic      accept;
  logic      pend;
  logic      vs_edge;
  logic      cls_attr;
  bus_kind_e cls_kind;
  bus_kind_e kind_q;

  assign fetch_ready = !out_valid || bus_ready;
  assign accept      = fetch_valid && fetch_ready;

  tsc_resync_track u_track (
    .clk(clk), .rst(rst), .vsync_lvl(vsync_lvl), .accept(accept),
    .pend_o(pend), .edge_o(vs_edge)
  );

  tsc_classify u_cls (
    .indirect(fetch_indirect), .int_hit(fetch_int_hit), .resync(pend),
    .vsync_lvl(vsync_lvl), .show_mode(show_mode),
    .attr(cls_attr), .kind(cls_kind)
  );

  tsc_out_slice #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst), .load(accept), .take(bus_ready),
    .addr_i(fetch_addr), .attr_i(cls_attr), .kind_i(cls_kind), .resync_i(pend),
    .valid_o(out_valid), .addr_o(out_addr), .attr_o(out_attr),
    .kind_o(kind_q), .resync_o(out_resync)
  );

  assign out_kind = kind_q;

  // R6: illegal kind never produced
  a_r6_kind_legal: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_kind != 2'b11));
  // R4: resync fetch is marked and shown
  a_r4_resync_shown: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_resync) |-> (out_attr && out_kind != 2'b00));
  // R6: a hidden cycle never carries the attribute
  a_r6_none_noattr: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == 2'b00) |-> !out_attr);
  // R11: idle output after reset is clear
  a_r11_idle_clear: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_attr && out_kind == 2'b00));
endmodule

// File: tb/tb_trace_show_ctrl.sv
`timescale 1ns/1ps
module tb_trace_show_ctrl;
  localparam int AW = 32;
  logic clk = 0, rst = 1;
  logic fetch_valid = 0, fetch_indirect = 0, fetch_int_hit = 0;
  logic vsync_lvl = 0, bus_ready = 1;
  logic [AW-1:0] fetch_addr = '0;
  logic [1:0] show_mode = 2'b11;
  logic fetch_ready, out_valid, out_attr, out_resync;
  logic [AW-1:0] out_addr;
  logic [1:0] out_kind;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  trace_show_ctrl #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_addr(fetch_addr), .fetch_indirect(fetch_indirect),
    .fetch_int_hit(fetch_int_hit), .vsync_lvl(vsync_lvl), .show_mode(show_mode),
    .out_valid(out_valid), .bus_ready(bus_ready), .out_addr(out_addr),
    .out_attr(out_attr), .out_kind(out_kind), .out_resync(out_resync)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one fetch accepted at next edge; result checked one cycle later
  task automatic fetch(input string req, input logic [AW-1:0] a, input logic ind,
                       input logic hit, input logic e_attr, input logic [1:0] e_kind,
                       input logic e_rs);
    @(negedge clk);
    fetch_valid = 1; fetch_addr = a; fetch_indirect = ind; fetch_int_hit = hit;
    @(negedge clk);
    fetch_valid = 0;
    chk({req, " valid"}, out_valid, 1);
    chk({req, " addr"}, out_addr, a);
    chk({req, " attr"}, out_attr, e_attr);
    chk({req, " kind"}, out_kind, e_kind);
    chk({req, " resync"}, out_resync, e_rs);
  endtask

  task automatic set_vsync(input logic v);
    @(negedge clk); vsync_lvl = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1; repeat (3) @(negedge clk); rst = 0;
    chk("R11 out_valid", out_valid, 0);
    chk("R11 out_attr", out_attr, 0);
    chk("R11 out_kind", out_kind, 0);
    show_mode = 2'b11;
    fetch("R11 no pending resync", 32'h100, 0, 1, 0, 2'b00, 0);
  endtask

  task automatic t_mode_all;
    show_mode = 2'b00;
    fetch("R7 seq hit shown", 32'h200, 0, 1, 0, 2'b01, 0);
    fetch("R7 seq miss full", 32'h204, 0, 0, 0, 2'b10, 0);
    fetch("R1 indirect hit", 32'h300, 1, 1, 1, 2'b01, 0);
  endtask

  task automatic t_mode_marked;
    show_mode = 2'b01;
    fetch("R8 marked hit", 32'h400, 1, 1, 1, 2'b01, 0);
    fetch("R8 unmarked hit none", 32'h404, 0, 1, 0, 2'b00, 0);
    fetch("R2 seq miss", 32'h408, 0, 0, 0, 2'b10, 0);
  endtask

  task automatic t_mode_quiet;
    show_mode = 2'b11;
    fetch("R9 indirect hit hidden", 32'h500, 1, 1, 0, 2'b00, 0);
    fetch("R6 hidden miss full", 32'h504, 1, 0, 0, 2'b10, 0);
    show_mode = 2'b10;
    fetch("R9 mode10 as 11", 32'h508, 1, 1, 0, 2'b00, 0);
  endtask

  task automatic t_vsync;
    show_mode = 2'b11;
    set_vsync(1);
    fetch("R4 rise resync", 32'h600, 0, 1, 1, 2'b01, 1);
    fetch("R4 one only", 32'h604, 0, 1, 0, 2'b00, 0);
    fetch("R3 vsync marked hit", 32'h608, 1, 1, 1, 2'b01, 0);
    fetch("R3 vsync marked miss", 32'h60C, 1, 0, 1, 2'b10, 0);
    set_vsync(0);
    fetch("R4 fall resync", 32'h700, 0, 0, 1, 2'b10, 1);
    fetch("R9 after fall hidden", 32'h704, 1, 1, 0, 2'b00, 0);
  endtask

  task automatic t_edge_with_accept;
    show_mode = 2'b11;
    @(negedge clk);
    vsync_lvl = 1; fetch_valid = 1; fetch_addr = 32'h800;
    fetch_indirect = 0; fetch_int_hit = 1;
    @(negedge clk);
    fetch_valid = 0;
    chk("R5 coincident no resync", out_resync, 0);
    chk("R5 coincident kind", out_kind, 2'b00);
    fetch("R5 next has resync", 32'h804, 0, 1, 1, 2'b01, 1);
    fetch("R5 then cleared", 32'h808, 0, 1, 0, 2'b00, 0);
    set_vsync(0);
    fetch("R4 drain", 32'h80C, 0, 1, 1, 2'b01, 1);
  endtask

  task automatic t_backpressure;
    show_mode = 2'b00;
    @(negedge clk);
    bus_ready = 0; fetch_valid = 1; fetch_addr = 32'h900;
    fetch_indirect = 1; fetch_int_hit = 0;
    @(negedge clk);
    chk("R10 first out", out_addr, 32'h900);
    fetch_addr = 32'h904; fetch_indirect = 0;
    repeat (3) @(negedge clk);
    chk("R10 held addr", out_addr, 32'h900);
    chk("R10 held valid", out_valid, 1);
    chk("R10 ready low", fetch_ready, 0);
    bus_ready = 1;
    @(negedge clk);
    fetch_valid = 0;
    chk("R10 next addr", out_addr, 32'h904);
    chk("R10 next attr", out_attr, 0);
    @(negedge clk);
    chk("R10 drained", out_valid, 0);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_mode_all;
        t_mode_marked;
        t_mode_quiet;
        t_vsync;
        t_edge_with_accept;
        t_backpressure;
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule